// File: doc/BRIEF.md
# Rename History Buffer with Rollback

This block keeps an ordered log of the register renames made by an out-of-order core's rename stage. Each renamed destination adds one entry holding the instruction's sequence number, the architectural register, the physical register just assigned and the physical register it displaced. An instruction without destinations adds a single placeholder entry that carries only its sequence number, so that commit and squash still see every instruction in order.

Two walks take entries out of the log. A squash walk removes entries from the youngest end. For each real entry it issues a map-restore write (architectural register back to the displaced physical register) and returns the new physical register to the free list. A commit walk removes entries from the oldest end and returns each displaced physical register to the free list. The map table and free list sit outside the block and are seen only as write ports.

Walks move one entry per cycle and raise `busy`. The rename stage stalls on `busy` or `full`. Four event counters record placeholders added, maps committed, maps undone and real maps undone.

Top module: `rename_history_buf`

## Requirements
- R1: After reset the log is empty: `full`, `busy`, `map_wr_en` and `free_wr_en` are low and all four counters read zero.
- R2: When idle and not full, a request on `alloc_valid` appends one entry at the youngest end. With `alloc_placeholder` high the entry keeps only its sequence number and never produces a map or free write when it is later removed.
- R3: `full` is high exactly when DEPTH entries are held. A request on `alloc_valid` while full leaves the log unchanged.
- R4: After a squash with sequence S, entries are removed youngest first, one per cycle, while their sequence number is greater than S (unsigned compare, no wrap). Each real entry drives `map_wr_en` with (arch, previous phys) and `free_wr_en` with the new phys in the same cycle.
- R5: A squash that finds the log empty, or finds no entry younger than S, holds `busy` for exactly one cycle and produces no writes.
- R6: After a commit with sequence N, entries are removed oldest first, one per cycle, while their sequence number is at most N. Each real entry drives `free_wr_en` with its previous phys, and `map_wr_en` stays low.
- R7: A commit whose oldest entry is already younger than N removes nothing: `busy` lasts one cycle and no writes appear.
- R8: `busy` rises in the cycle after a squash or commit is accepted and stays high for (entries removed + 1) cycles. Alloc, squash and commit requests made while busy are ignored.
- R9: When idle, simultaneous requests are resolved squash first, then commit, then alloc; the losers are dropped.
- R10: `cnt_placeholders` counts placeholder appends, `cnt_committed` counts real entries removed by commit, `cnt_undone` counts all entries removed by squash, and `cnt_undone_valid` counts real entries removed by squash.
- R11: An instruction with several destinations appends one entry per destination under a shared sequence number, and a squash or commit removes all of them together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Append one entry |
| alloc_seq | input | SEQ_W | Sequence number of the appended entry |
| alloc_placeholder | input | 1 | Entry stands for an instruction with no destination |
| alloc_arch | input | ARCH_W | Architectural destination register |
| alloc_new_phys | input | PHYS_W | Physical register just assigned |
| alloc_prev_phys | input | PHYS_W | Physical register previously mapped |
| squash_valid | input | 1 | Start a squash walk |
| squash_seq | input | SEQ_W | Last surviving sequence number |
| commit_valid | input | 1 | Start a commit walk |
| commit_seq | input | SEQ_W | Sequence number that has completed |
| full | output | 1 | Log holds DEPTH entries |
| busy | output | 1 | A walk is in progress |
| map_wr_en | output | 1 | Map-restore write strobe |
| map_wr_arch | output | ARCH_W | Architectural register to restore |
| map_wr_phys | output | PHYS_W | Physical register to restore |
| free_wr_en | output | 1 | Free-list return strobe |
| free_wr_phys | output | PHYS_W | Physical register returned |
| cnt_placeholders | output | STAT_W | Placeholder entries appended |
| cnt_committed | output | STAT_W | Real entries retired by commit |
| cnt_undone | output | STAT_W | Entries removed by squash |
| cnt_undone_valid | output | STAT_W | Real entries removed by squash |

## Verification
A wrong head or tail pointer shows up on the next walk. The restore or free write carries the wrong register pair, or its order is not youngest-first or oldest-first, within the cycles of that walk. A miscounted occupancy shows up as `full` at the wrong fill level, or as a walk that ends after the wrong number of cycles. A faulty stop condition shows up as a `busy` length different from removed + 1, or as extra or missing free writes. The scoreboard catches each of these on the first write or the first `busy` cycle that departs from the reference log kept in the bench.

// File: rtl/rhb_pkg.sv
package rhb_pkg;

  typedef enum logic [1:0] {
    WALK_IDLE   = 2'd0,
    WALK_SQUASH = 2'd1,
    WALK_COMMIT = 2'd2
  } walk_e;

  // Unsigned sequence order, no wrap handling; callers widen to 32 bits.
  function automatic logic seq_younger(input logic [31:0] a, input logic [31:0] b);
    return a > b;
  endfunction

endpackage

// File: rtl/rhb_store.sv
module rhb_store #(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 16,
  parameter int ARCH_W = 5,
  parameter int PHYS_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic              push_ph,
  input  logic [ARCH_W-1:0] push_arch,
  input  logic [PHYS_W-1:0] push_new,
  input  logic [PHYS_W-1:0] push_prev,
  input  logic              pop_old,
  input  logic              pop_young,
  output logic [SEQ_W-1:0]  old_seq,
  output logic              old_ph,
  output logic [PHYS_W-1:0] old_prev,
  output logic [SEQ_W-1:0]  young_seq,
  output logic              young_ph,
  output logic [ARCH_W-1:0] young_arch,
  output logic [PHYS_W-1:0] young_new,
  output logic [PHYS_W-1:0] young_prev,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [SEQ_W-1:0]  seq_mem  [DEPTH];
  logic              ph_mem   [DEPTH];
  logic [ARCH_W-1:0] arch_mem [DEPTH];
  logic [PHYS_W-1:0] new_mem  [DEPTH];
  logic [PHYS_W-1:0] prev_mem [DEPTH];

  logic [PTR_W-1:0] head_q, tail_q, young_idx;
  logic [CNT_W-1:0] count_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST : p - 1'b1;
  endfunction

  assign young_idx = ptr_dec(tail_q);
  assign empty     = (count_q == '0);
  assign full      = (count_q == CNT_W'(DEPTH));

  assign old_seq    = seq_mem[head_q];
  assign old_ph     = ph_mem[head_q];
  assign old_prev   = prev_mem[head_q];
  assign young_seq  = seq_mem[young_idx];
  assign young_ph   = ph_mem[young_idx];
  assign young_arch = arch_mem[young_idx];
  assign young_new  = new_mem[young_idx];
  assign young_prev = prev_mem[young_idx];

  always_ff @(posedge clk) begin
    if (push) begin
      seq_mem[tail_q]  <= push_seq;
      ph_mem[tail_q]   <= push_ph;
      arch_mem[tail_q] <= push_arch;
      new_mem[tail_q]  <= push_new;
      prev_mem[tail_q] <= push_prev;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push)      tail_q <= ptr_inc(tail_q);
      if (pop_young) tail_q <= young_idx;
      if (pop_old)   head_q <= ptr_inc(head_q);
      count_q <= count_q + CNT_W'(push) - CNT_W'(pop_old) - CNT_W'(pop_young);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count_q < CNT_W'(DEPTH)));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_old || pop_young) |-> !empty);
  assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop_old && !pop_young) |=> !empty);

endmodule

// File: rtl/rhb_walker.sv
module rhb_walker #(
  parameter int SEQ_W  = 16,
  parameter int ARCH_W = 5,
  parameter int PHYS_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              squash_req,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              commit_req,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              alloc_req,
  input  logic              full,
  input  logic              empty,
  input  logic [SEQ_W-1:0]  old_seq,
  input  logic              old_ph,
  input  logic [PHYS_W-1:0] old_prev,
  input  logic [SEQ_W-1:0]  young_seq,
  input  logic              young_ph,
  input  logic [ARCH_W-1:0] young_arch,
  input  logic [PHYS_W-1:0] young_new,
  input  logic [PHYS_W-1:0] young_prev,
  output logic              push,
  output logic              pop_old,
  output logic              pop_young,
  output logic              busy,
  output logic              map_wr_en,
  output logic [ARCH_W-1:0] map_wr_arch,
  output logic [PHYS_W-1:0] map_wr_phys,
  output logic              free_wr_en,
  output logic [PHYS_W-1:0] free_wr_phys
);
  import rhb_pkg::*;

  walk_e            state_q, state_d;
  logic [SEQ_W-1:0] tgt_q, tgt_d;
  logic             young_after, old_after;

  assign young_after = seq_younger(32'(young_seq), 32'(tgt_q));
  assign old_after   = seq_younger(32'(old_seq), 32'(tgt_q));

  assign busy      = (state_q != WALK_IDLE);
  assign push      = (state_q == WALK_IDLE) && !squash_req && !commit_req && alloc_req && !full;
  assign pop_young = (state_q == WALK_SQUASH) && !empty && young_after;
  assign pop_old   = (state_q == WALK_COMMIT) && !empty && !old_after;

  assign map_wr_en    = pop_young && !young_ph;
  assign map_wr_arch  = young_arch;
  assign map_wr_phys  = young_prev;
  assign free_wr_en   = (pop_young && !young_ph) || (pop_old && !old_ph);
  assign free_wr_phys = pop_young ? young_new : old_prev;

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    unique case (state_q)
      WALK_IDLE: begin
        if (squash_req) begin
          state_d = WALK_SQUASH;
          tgt_d   = squash_seq;
        end else if (commit_req) begin
          state_d = WALK_COMMIT;
          tgt_d   = commit_seq;
        end
      end
      WALK_SQUASH: if (!pop_young) state_d = WALK_IDLE;
      WALK_COMMIT: if (!pop_old)   state_d = WALK_IDLE;
      default:     state_d = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      tgt_q   <= '0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
    end
  end

  assert_restore_pairs_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr_en |-> (free_wr_en && busy));
  assert_squash_stops_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WALK_SQUASH && !pop_young) |=> (empty || !young_after));
  assert_commit_stops_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WALK_COMMIT && !pop_old) |=> (empty || old_after));
  assert_idle_no_push_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !push);

endmodule

// File: rtl/rhb_counters.sv
module rhb_counters #(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              push_ph,
  input  logic              pop_old,
  input  logic              old_ph,
  input  logic              pop_young,
  input  logic              young_ph,
  output logic [STAT_W-1:0] cnt_placeholders,
  output logic [STAT_W-1:0] cnt_committed,
  output logic [STAT_W-1:0] cnt_undone,
  output logic [STAT_W-1:0] cnt_undone_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_placeholders <= '0;
      cnt_committed    <= '0;
      cnt_undone       <= '0;
      cnt_undone_valid <= '0;
    end else begin
      if (push && push_ph)       cnt_placeholders <= cnt_placeholders + 1'b1;
      if (pop_old && !old_ph)    cnt_committed    <= cnt_committed + 1'b1;
      if (pop_young)             cnt_undone       <= cnt_undone + 1'b1;
      if (pop_young && !young_ph) cnt_undone_valid <= cnt_undone_valid + 1'b1;
    end
  end

  assert_undone_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop_young |=> (cnt_undone == $past(cnt_undone) + STAT_W'(1)));

endmodule

// File: rtl/rename_history_buf.sv
module rename_history_buf #(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 16,
  parameter int ARCH_W = 5,
  parameter int PHYS_W = 7,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic              alloc_placeholder,
  input  logic [ARCH_W-1:0] alloc_arch,
  input  logic [PHYS_W-1:0] alloc_new_phys,
  input  logic [PHYS_W-1:0] alloc_prev_phys,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  output logic              full,
  output logic              busy,
  output logic              map_wr_en,
  output logic [ARCH_W-1:0] map_wr_arch,
  output logic [PHYS_W-1:0] map_wr_phys,
  output logic              free_wr_en,
  output logic [PHYS_W-1:0] free_wr_phys,
  output logic [STAT_W-1:0] cnt_placeholders,
  output logic [STAT_W-1:0] cnt_committed,
  output logic [STAT_W-1:0] cnt_undone,
  output logic [STAT_W-1:0] cnt_undone_valid
);
  logic              push, pop_old, pop_young, empty;
  logic [SEQ_W-1:0]  old_seq, young_seq;
  logic              old_ph, young_ph;
  logic [PHYS_W-1:0] old_prev, young_new, young_prev;
  logic [ARCH_W-1:0] young_arch;
  logic [ARCH_W-1:0] st_arch;
  logic [PHYS_W-1:0] st_new, st_prev;

  // Placeholder entries keep only the sequence number.
  assign st_arch = alloc_placeholder ? '0 : alloc_arch;
  assign st_new  = alloc_placeholder ? '0 : alloc_new_phys;
  assign st_prev = alloc_placeholder ? '0 : alloc_prev_phys;

  rhb_store #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_seq(alloc_seq), .push_ph(alloc_placeholder),
    .push_arch(st_arch), .push_new(st_new), .push_prev(st_prev),
    .pop_old(pop_old), .pop_young(pop_young),
    .old_seq(old_seq), .old_ph(old_ph), .old_prev(old_prev),
    .young_seq(young_seq), .young_ph(young_ph), .young_arch(young_arch),
    .young_new(young_new), .young_prev(young_prev),
    .empty(empty), .full(full)
  );

  rhb_walker #(.SEQ_W(SEQ_W), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)) u_walker (
    .clk(clk), .rst_n(rst_n),
    .squash_req(squash_valid), .squash_seq(squash_seq),
    .commit_req(commit_valid), .commit_seq(commit_seq),
    .alloc_req(alloc_valid), .full(full), .empty(empty),
    .old_seq(old_seq), .old_ph(old_ph), .old_prev(old_prev),
    .young_seq(young_seq), .young_ph(young_ph), .young_arch(young_arch),
    .young_new(young_new), .young_prev(young_prev),
    .push(push), .pop_old(pop_old), .pop_young(pop_young), .busy(busy),
    .map_wr_en(map_wr_en), .map_wr_arch(map_wr_arch), .map_wr_phys(map_wr_phys),
    .free_wr_en(free_wr_en), .free_wr_phys(free_wr_phys)
  );

  rhb_counters #(.STAT_W(STAT_W)) u_counters (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_ph(alloc_placeholder),
    .pop_old(pop_old), .old_ph(old_ph),
    .pop_young(pop_young), .young_ph(young_ph),
    .cnt_placeholders(cnt_placeholders), .cnt_committed(cnt_committed),
    .cnt_undone(cnt_undone), .cnt_undone_valid(cnt_undone_valid)
  );

  assert_full_not_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !empty);
  assert_walk_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_old && pop_young) && !(push && (pop_old || pop_young)));

endmodule

// File: tb/rename_history_buf_test.sv
module rename_history_buf_test;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int SEQ_W  = 16;
  localparam int ARCH_W = 5;
  localparam int PHYS_W = 7;
  localparam int STAT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0, alloc_placeholder = 1'b0;
  logic [SEQ_W-1:0]  alloc_seq = '0;
  logic [ARCH_W-1:0] alloc_arch = '0;
  logic [PHYS_W-1:0] alloc_new_phys = '0, alloc_prev_phys = '0;
  logic squash_valid = 1'b0, commit_valid = 1'b0;
  logic [SEQ_W-1:0] squash_seq = '0, commit_seq = '0;
  logic full, busy, map_wr_en, free_wr_en;
  logic [ARCH_W-1:0] map_wr_arch;
  logic [PHYS_W-1:0] map_wr_phys, free_wr_phys;
  logic [STAT_W-1:0] cnt_placeholders, cnt_committed, cnt_undone, cnt_undone_valid;

  rename_history_buf #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ARCH_W(ARCH_W),
                       .PHYS_W(PHYS_W), .STAT_W(STAT_W)) uut (.*);

  always #(PERIOD/2) clk = ~clk;

  typedef struct { int seq; bit ph; int arch; int newp; int prevp; } ent_t;
  typedef struct { bit map_en; int arch; int mphys; int fphys; } exp_t;

  ent_t  model[$];
  exp_t  expq[$];
  int    n_checks = 0, n_err = 0;
  int    e_ph = 0, e_comm = 0, e_undo = 0, e_undo_v = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: compares every write against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (map_wr_en && !free_wr_en) check(1'b0, cur_req, 1, 0);
      if (free_wr_en) begin
        if (expq.size() == 0) check(1'b0, cur_req, int'(free_wr_phys), -1);
        else begin
          exp_t e;
          e = expq.pop_front();
          check(map_wr_en == e.map_en, cur_req, int'(map_wr_en), int'(e.map_en));
          check(int'(free_wr_phys) == e.fphys, cur_req, int'(free_wr_phys), e.fphys);
          if (e.map_en) begin
            check(int'(map_wr_arch) == e.arch, cur_req, int'(map_wr_arch), e.arch);
            check(int'(map_wr_phys) == e.mphys, cur_req, int'(map_wr_phys), e.mphys);
          end
        end
      end
    end
  end

  task automatic do_alloc(input int seq, input bit ph, input int arch, input int np, input int pp);
    @(negedge clk);
    check(full == (model.size() == DEPTH), "R3", int'(full), int'(model.size() == DEPTH));
    alloc_valid = 1'b1; alloc_seq = SEQ_W'(seq); alloc_placeholder = ph;
    alloc_arch = ARCH_W'(arch); alloc_new_phys = PHYS_W'(np); alloc_prev_phys = PHYS_W'(pp);
    if (model.size() < DEPTH) begin
      model.push_back('{seq, ph, ph ? 0 : arch, ph ? 0 : np, ph ? 0 : pp});
      if (ph) e_ph++;
    end
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  function automatic int model_squash(input int s);
    int k = 0;
    while (model.size() > 0 && model[$].seq > s) begin
      ent_t e;
      e = model.pop_back();
      if (!e.ph) begin expq.push_back('{1'b1, e.arch, e.prevp, e.newp}); e_undo_v++; end
      e_undo++; k++;
    end
    return k;
  endfunction

  function automatic int model_commit(input int n);
    int k = 0;
    while (model.size() > 0 && model[0].seq <= n) begin
      ent_t e;
      e = model.pop_front();
      if (!e.ph) begin expq.push_back('{1'b0, 0, 0, e.prevp}); e_comm++; end
      k++;
    end
    return k;
  endfunction

  // Waits out a walk; optionally fires stray requests in its first busy cycle.
  task automatic wait_walk(input int k, input bit inject, input string req);
    int cyc = 0;
    while (busy) begin
      cyc++;
      if (inject && cyc == 1) begin
        alloc_valid = 1'b1; alloc_seq = 16'd77; alloc_placeholder = 1'b0;
        alloc_arch = 5'd9; alloc_new_phys = 7'd99; alloc_prev_phys = 7'd9;
        commit_valid = 1'b1; commit_seq = '1;
        squash_valid = 1'b1; squash_seq = '0;
      end else begin
        alloc_valid = 1'b0; commit_valid = 1'b0; squash_valid = 1'b0;
      end
      @(negedge clk);
    end
    alloc_valid = 1'b0; commit_valid = 1'b0; squash_valid = 1'b0;
    check(cyc == k + 1, req, cyc, k + 1);
    check(expq.size() == 0, req, expq.size(), 0);
  endtask

  task automatic do_squash(input int s, input bit inject, input string req);
    int k;
    cur_req = req;
    k = model_squash(s);
    @(negedge clk);
    squash_valid = 1'b1; squash_seq = SEQ_W'(s);
    @(negedge clk);
    squash_valid = 1'b0;
    wait_walk(k, inject, req);
  endtask

  task automatic do_commit(input int n, input string req);
    int k;
    cur_req = req;
    k = model_commit(n);
    @(negedge clk);
    commit_valid = 1'b1; commit_seq = SEQ_W'(n);
    @(negedge clk);
    commit_valid = 1'b0;
    wait_walk(k, 1'b0, req);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!full && !busy, "R1", int'({full, busy}), 0);
    check(!map_wr_en && !free_wr_en, "R1", int'({map_wr_en, free_wr_en}), 0);
    check(cnt_placeholders == 0 && cnt_committed == 0 && cnt_undone == 0 && cnt_undone_valid == 0,
          "R1", int'(cnt_undone), 0);
    rst_n = 1'b1;

    // R2 / R11: real, placeholder and two-destination instructions
    do_alloc(1, 1'b0, 3, 40, 3);
    do_alloc(2, 1'b1, 7, 7, 7);
    do_alloc(3, 1'b0, 5, 41, 5);
    do_alloc(3, 1'b0, 6, 42, 6);
    do_alloc(4, 1'b0, 3, 43, 40);

    do_commit(1, "R6");                 // frees 3
    do_commit(0, "R7");                 // oldest younger than 0: ignored
    do_squash(2, 1'b1, "R8");           // removes 4, 3b, 3a (R4, R11); strays ignored
    do_squash(5, 1'b0, "R5");           // nothing younger
    do_commit(2, "R2");                 // placeholder leaves with no write
    do_squash(0, 1'b0, "R5");           // empty log

    // R9: squash beats commit and alloc in the same cycle
    do_alloc(10, 1'b0, 1, 50, 1);
    do_alloc(11, 1'b0, 2, 51, 2);
    cur_req = "R9";
    k = model_squash(10);
    @(negedge clk);
    squash_valid = 1'b1; squash_seq = 16'd10;
    commit_valid = 1'b1; commit_seq = 16'd11;
    alloc_valid = 1'b1; alloc_seq = 16'd12; alloc_placeholder = 1'b0;
    alloc_arch = 5'd4; alloc_new_phys = 7'd52; alloc_prev_phys = 7'd4;
    @(negedge clk);
    squash_valid = 1'b0; commit_valid = 1'b0; alloc_valid = 1'b0;
    wait_walk(k, 1'b0, "R9");
    do_commit(20, "R9");                // only seq 10 remains

    // R3: fill, overfill, drain
    for (int i = 0; i < DEPTH; i++) do_alloc(30 + i, 1'b0, i, 60 + i, 20 + i);
    @(negedge clk);
    check(full == 1'b1, "R3", int'(full), 1);
    do_alloc(90, 1'b0, 11, 100, 11);    // dropped while full
    do_commit(100, "R3");
    check(full == 1'b0, "R3", int'(full), 0);

    // R10 counters
    check(int'(cnt_placeholders) == e_ph, "R10", int'(cnt_placeholders), e_ph);
    check(int'(cnt_committed) == e_comm, "R10", int'(cnt_committed), e_comm);
    check(int'(cnt_undone) == e_undo, "R10", int'(cnt_undone), e_undo);
    check(int'(cnt_undone_valid) == e_undo_v, "R10", int'(cnt_undone_valid), e_undo_v);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule